// File: doc/BRIEF.md
# Descriptor-Chained Memory-to-FIFO DMA Engine

This block moves data out of memory into the transmit data FIFO of an SD/MMC card interface. Software does not hand it a single buffer. It builds a chain of descriptors in memory, one per buffer segment. It then gives the engine the address of the first descriptor and writes a control word with the enable bit set. The engine reads each descriptor over a simple read port and streams the segment's words into the FIFO. It then follows the next pointer. When it finishes the segment of the descriptor marked as the end, it stops and raises a completion flag.

Each descriptor is four 32-bit words at consecutive addresses: the next-descriptor address at +0, the buffer address at +4, the length in bytes at +8 and the command word at +12. A buffer may start at any byte. The control word can ask for a byte offset, and the engine then reads one extra word per segment and repacks the bytes so that the FIFO sees the segment's bytes starting at that offset. A control write with the enable bit clear stops a transfer at once and raises no flag. The current descriptor address, the buffer position, the bytes still to deliver and the descriptor index are visible on status outputs.

Top module: `ldma_engine`

## Requirements
- R1: A register write with `reg_sel`=0 stores the first-descriptor address, and its low two bits are ignored. A write with `reg_sel`=1 and control bit 0 (enable) set while idle starts the engine: `busy` is high after the next clock edge, and the first memory request is for that address.
- R2: Each descriptor is read as four word requests at its address +0, +4, +8 and +12, in that order. The four words mean next-descriptor address, buffer address, length in bytes and command word. All four are read before any data request for that segment.
- R3: In the command word, bit 1 marks the last descriptor and bits 31:16 carry the descriptor index shown on `stat_desc_idx`. When the last data word of a descriptor with bit 1 set has been accepted, `busy` falls and `dma_end` rises. With bit 1 clear, the engine fetches the descriptor at the next-descriptor address (low two bits ignored), whatever the state of bit 0 (link).
- R4: A segment's data is read from consecutive word addresses, starting at the buffer address with its low two bits cleared. Its length is taken as length/4 words, so the low two bits of the length are ignored. Every word reaches `fifo_data` in address order, with no loss or duplication.
- R5: When control bit 1 (align enable) is set and control bits 3:2 hold an offset k≠0, every non-empty segment reads length/4+1 words. FIFO word i then carries the bytes at offsets 4i+k to 4i+k+3 from the aligned base, lowest address in bits 7:0. With bit 1 clear, bits 3:2 have no effect.
- R6: A descriptor with length below 4 causes no data request, even with an offset. The engine goes straight on to the next descriptor, or finishes if the descriptor is the last one.
- R7: A control write with bit 0 clear makes `busy`, `fifo_valid` and `dma_end` low after the next edge, and no further FIFO word appears. A memory response that was outstanding at that moment is discarded, and a transfer started right after still reads its descriptors correctly.
- R8: `dma_end` stays high until the next control write. A control write with bit 0 set while `busy` is high is ignored.
- R9: `stat_desc_addr` shows the current descriptor address. `stat_buf_addr` shows the segment's buffer address plus the bytes already delivered. `stat_remain` shows the bytes still to deliver, and it falls by 4 for each accepted FIFO word.
- R10: A memory request is held with a stable address until `mem_req_ready`. A FIFO word is held stable until `fifo_ready`. Only one memory request is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0: first-descriptor address, 1: control word |
| reg_wdata | input | 32 | Register write data |
| mem_req_valid | output | 1 | Word read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Read data |
| fifo_valid | output | 1 | FIFO word available |
| fifo_ready | input | 1 | FIFO takes the word |
| fifo_data | output | 32 | FIFO word |
| busy | output | 1 | Engine walking a chain |
| dma_end | output | 1 | Chain completed |
| stat_desc_addr | output | 32 | Current descriptor address |
| stat_buf_addr | output | 32 | Next buffer byte to deliver |
| stat_remain | output | 32 | Bytes left in the segment |
| stat_desc_idx | output | 16 | Index field of the current descriptor |

## Verification
The chains are tried in several shapes: a single aligned descriptor, a three-link chain holding an empty segment and a length with stray low bits, two offset chains (offsets 1 and 3), an offset given without align enable, and an empty last segment with an offset. Between them, these separate the link walk, the rule that rounds the length down, the extra-word repacking and the case where the offset is ignored. Memory latency, request acceptance and FIFO readiness vary between runs, so lost or repeated words and unstable handshakes show up. An abort is issued while a slow read is still outstanding and is followed at once by a fresh chain, which exposes any stale response taken as a descriptor word.

// File: rtl/ldma_pkg.sv
package ldma_pkg;
    localparam int WORD_W     = 32;
    localparam int IDX_W      = 16;
    localparam int IDX_LO     = 16;
    localparam int LANES      = WORD_W / 8;
    localparam int SH_W       = $clog2(LANES);
    localparam int CTL_EN     = 0;
    localparam int CTL_ALN    = 1;
    localparam int CTL_OFS_LO = 2;
    localparam int CMD_END    = 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DATA  = 2'd2
    } ldma_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] first_addr;
        logic [SH_W-1:0]   shift;
    } ctl_regs_t;

    typedef struct packed {
        ldma_state_e       st;
        logic [1:0]        widx;
        logic [WORD_W-1:0] desc;
        logic [WORD_W-1:0] nxt;
        logic [WORD_W-1:0] bufa;
        logic [WORD_W-1:0] rd_addr;
        logic [WORD_W-1:0] cur;
        logic [WORD_W-1:0] remain;
        logic [WORD_W-1:0] rd_left;
        logic              last;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] prev;
        logic [WORD_W-1:0] odata;
        logic              primed;
        logic              ovalid;
        logic              pend;
        logic              stale;
        logic              done;
    } seq_regs_t;
endpackage

// File: rtl/ldma_ctrl_regs.sv
module ldma_ctrl_regs
    import ldma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic              busy,
    output logic [WORD_W-1:0] first_addr,
    output logic [SH_W-1:0]   shift,
    output logic              start,
    output logic              abort,
    output logic              clr_end
);
    ctl_regs_t q, d;
    logic ctl_wr;

    always_comb begin
        d       = q;
        ctl_wr  = reg_wr & reg_sel;
        start   = ctl_wr & reg_wdata[CTL_EN] & ~busy;
        abort   = ctl_wr & ~reg_wdata[CTL_EN];
        clr_end = ctl_wr;
        if (reg_wr && !reg_sel) begin
            d.first_addr = {reg_wdata[WORD_W-1:2], 2'b00};
        end
        if (start) begin
            d.shift = reg_wdata[CTL_ALN] ? reg_wdata[CTL_OFS_LO +: SH_W] : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign first_addr = q.first_addr;
    assign shift      = q.shift;

    assert_shift_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !start |=> $stable(shift));
endmodule

// File: rtl/ldma_byte_align.sv
module ldma_byte_align
    import ldma_pkg::*;
(
    input  logic [WORD_W-1:0] lo_word,
    input  logic [WORD_W-1:0] hi_word,
    input  logic [SH_W-1:0]   shift,
    output logic [WORD_W-1:0] out_word
);
    logic [2*WORD_W-1:0] cat;
    assign cat = {hi_word, lo_word};

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign out_word[8*l +: 8] = cat[8 * (l + int'(shift)) +: 8];
    end
endmodule

// File: rtl/ldma_seq.sv
module ldma_seq
    import ldma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic              clr_end,
    input  logic [WORD_W-1:0] first_addr,
    input  logic [SH_W-1:0]   shift,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [WORD_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data,
    output logic              fifo_valid,
    input  logic              fifo_ready,
    output logic [WORD_W-1:0] fifo_data,
    output logic              busy,
    output logic              dma_end,
    output logic [WORD_W-1:0] stat_desc_addr,
    output logic [WORD_W-1:0] stat_buf_addr,
    output logic [WORD_W-1:0] stat_remain,
    output logic [IDX_W-1:0]  stat_desc_idx
);
    seq_regs_t q, d;
    logic accept, take, pop;
    logic [WORD_W-1:0] aligned;

    ldma_byte_align u_align (
        .lo_word  (q.prev),
        .hi_word  (mem_rsp_data),
        .shift    (shift),
        .out_word (aligned)
    );

    assign mem_req_valid = ~q.pend &
        ((q.st == ST_FETCH) ||
         (q.st == ST_DATA && q.rd_left != '0 && !q.ovalid));
    assign mem_req_addr  = (q.st == ST_FETCH) ? (q.desc + {{(WORD_W-4){1'b0}}, q.widx, 2'b00})
                                              : q.rd_addr;

    always_comb begin
        d      = q;
        accept = mem_req_valid & mem_req_ready;
        take   = mem_rsp_valid & ~q.stale;
        pop    = q.ovalid & fifo_ready;
        d.pend = (q.pend & ~mem_rsp_valid) | accept;
        if (mem_rsp_valid && q.stale) d.stale = 1'b0;
        if (clr_end) d.done = 1'b0;

        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st   = ST_FETCH;
                    d.desc = first_addr;
                    d.widx = 2'd0;
                end
            end
            ST_FETCH: begin
                if (take) begin
                    d.widx = q.widx + 2'd1;
                    case (q.widx)
                        2'd0: d.nxt    = {mem_rsp_data[WORD_W-1:2], 2'b00};
                        2'd1: d.bufa   = mem_rsp_data;
                        2'd2: d.remain = {mem_rsp_data[WORD_W-1:2], 2'b00};
                        default: begin
                            d.last    = mem_rsp_data[CMD_END];
                            d.idx     = mem_rsp_data[IDX_LO +: IDX_W];
                            d.st      = ST_DATA;
                            d.rd_addr = {q.bufa[WORD_W-1:2], 2'b00};
                            d.cur     = q.bufa;
                            d.primed  = 1'b0;
                            d.rd_left = (q.remain == '0) ? '0
                                      : (q.remain >> 2) + WORD_W'(shift != '0);
                        end
                    endcase
                end
            end
            ST_DATA: begin
                if (take) begin
                    d.rd_addr = q.rd_addr + WORD_W'(4);
                    d.rd_left = q.rd_left - WORD_W'(1);
                    if (shift == '0) begin
                        d.ovalid = 1'b1;
                        d.odata  = mem_rsp_data;
                    end else if (!q.primed) begin
                        d.prev   = mem_rsp_data;
                        d.primed = 1'b1;
                    end else begin
                        d.ovalid = 1'b1;
                        d.odata  = aligned;
                        d.prev   = mem_rsp_data;
                    end
                end
                if (pop) begin
                    d.ovalid = 1'b0;
                    d.remain = q.remain - WORD_W'(4);
                    d.cur    = q.cur + WORD_W'(4);
                end
                if (q.remain == '0 && !q.ovalid) begin
                    if (q.last) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.st   = ST_FETCH;
                        d.desc = q.nxt;
                        d.widx = 2'd0;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (abort) begin
            d.st     = ST_IDLE;
            d.ovalid = 1'b0;
            d.done   = 1'b0;
            d.widx   = 2'd0;
            d.stale  = d.pend;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fifo_valid     = q.ovalid;
    assign fifo_data      = q.odata;
    assign busy           = (q.st != ST_IDLE);
    assign dma_end        = q.done;
    assign stat_desc_addr = q.desc;
    assign stat_buf_addr  = q.cur;
    assign stat_remain    = q.remain;
    assign stat_desc_idx  = q.idx;

    assert_start_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    assert_end_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_end) |-> !busy);
    assert_abort_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !busy && !fifo_valid && !dma_end);
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !fifo_valid && !mem_req_valid);
    assert_remain_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_valid && fifo_ready && !abort |=> stat_remain == $past(stat_remain) - 32'd4);
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready && !abort |=> mem_req_valid && $stable(mem_req_addr));
    assert_fifo_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_valid && !fifo_ready && !abort |=> fifo_valid && $stable(fifo_data));
endmodule

// File: rtl/ldma_engine.sv
module ldma_engine
    import ldma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [WORD_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data,
    output logic              fifo_valid,
    input  logic              fifo_ready,
    output logic [WORD_W-1:0] fifo_data,
    output logic              busy,
    output logic              dma_end,
    output logic [WORD_W-1:0] stat_desc_addr,
    output logic [WORD_W-1:0] stat_buf_addr,
    output logic [WORD_W-1:0] stat_remain,
    output logic [IDX_W-1:0]  stat_desc_idx
);
    logic [WORD_W-1:0] first_addr;
    logic [SH_W-1:0]   shift;
    logic              start, abort, clr_end;

    ldma_ctrl_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .busy       (busy),
        .first_addr (first_addr),
        .shift      (shift),
        .start      (start),
        .abort      (abort),
        .clr_end    (clr_end)
    );

    ldma_seq u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start),
        .abort          (abort),
        .clr_end        (clr_end),
        .first_addr     (first_addr),
        .shift          (shift),
        .mem_req_valid  (mem_req_valid),
        .mem_req_ready  (mem_req_ready),
        .mem_req_addr   (mem_req_addr),
        .mem_rsp_valid  (mem_rsp_valid),
        .mem_rsp_data   (mem_rsp_data),
        .fifo_valid     (fifo_valid),
        .fifo_ready     (fifo_ready),
        .fifo_data      (fifo_data),
        .busy           (busy),
        .dma_end        (dma_end),
        .stat_desc_addr (stat_desc_addr),
        .stat_buf_addr  (stat_buf_addr),
        .stat_remain    (stat_remain),
        .stat_desc_idx  (stat_desc_idx)
    );
endmodule

// File: tb/ldma_engine_tb.sv
`timescale 1ns/1ps
module ldma_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr, reg_sel;
    logic [31:0] reg_wdata;
    logic        mem_req_valid, mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        fifo_valid, fifo_ready;
    logic [31:0] fifo_data;
    logic        busy, dma_end;
    logic [31:0] stat_desc_addr, stat_buf_addr, stat_remain;
    logic [15:0] stat_desc_idx;

    logic [31:0] mem [0:511];
    logic [31:0] exp_data_q[$];
    logic [31:0] exp_addr_q[$];
    int checks = 0, errors = 0;
    int lat = 1, ready_mode = 0, sink_mode = 0, cyc = 0, cnt = 0;
    bit outstanding = 0, finished = 0;
    logic [31:0] pend_addr;

    always #2 clk = ~clk;

    ldma_engine u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .fifo_valid(fifo_valid), .fifo_ready(fifo_ready), .fifo_data(fifo_data),
        .busy(busy), .dma_end(dma_end), .stat_desc_addr(stat_desc_addr),
        .stat_buf_addr(stat_buf_addr), .stat_remain(stat_remain), .stat_desc_idx(stat_desc_idx)
    );

    function automatic logic [31:0] rdm(input logic [31:0] a);
        return mem[a[10:2]];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory model and FIFO sink; scoreboard monitor.
    initial begin
        mem_rsp_valid = 1'b0; mem_rsp_data = '0; mem_req_ready = 1'b0; fifo_ready = 1'b0;
        forever begin
            @(negedge clk);
            cyc++;
            mem_rsp_valid = 1'b0;
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = rdm(pend_addr);
                    outstanding   = 0;
                end
            end
            mem_req_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 2) == 0);
            fifo_ready    = (sink_mode == 0) ? 1'b1 : (sink_mode == 1) ? ((cyc % 3) != 0) : 1'b0;
            if (rst_n && mem_req_valid && mem_req_ready) begin
                pend_addr   = mem_req_addr;
                cnt         = lat;
                outstanding = 1;
                if (exp_addr_q.size() == 0) chk(0, "R2 unexpected request", mem_req_addr, '0);
                else begin
                    logic [31:0] e;
                    e = exp_addr_q.pop_front();
                    chk(mem_req_addr == e, "R2/R4 request address", mem_req_addr, e);
                end
            end
            if (rst_n && fifo_valid && fifo_ready) begin
                if (exp_data_q.size() == 0) chk(0, "R4 unexpected FIFO word", fifo_data, '0);
                else begin
                    logic [31:0] e;
                    e = exp_data_q.pop_front();
                    chk(fifo_data == e, "R4/R5 FIFO word", fifo_data, e);
                end
            end
        end
    end

    task automatic wr_reg(input bit sel, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic start_chain(input logic [31:0] a, input logic [31:0] ctl);
        wr_reg(1'b0, a);
        wr_reg(1'b1, ctl);
        chk(busy == 1'b1, "R1 busy after start", {31'd0, busy}, 32'd1);
    endtask

    // Driver: places a descriptor and pushes its expected trace.
    task automatic put_desc(input logic [31:0] da, input logic [31:0] nxt, input logic [31:0] bufa,
                            input logic [31:0] len, input logic [31:0] cmd, input int sh);
        logic [31:0] base, n;
        mem[da[10:2]]     = nxt;
        mem[da[10:2] + 1] = bufa;
        mem[da[10:2] + 2] = len;
        mem[da[10:2] + 3] = cmd;
        for (int j = 0; j < 4; j++) exp_addr_q.push_back(da + 32'(4 * j));
        base = {bufa[31:2], 2'b00};
        n    = len >> 2;
        if (n > 0) begin
            for (int j = 0; j < int'(n) + ((sh != 0) ? 1 : 0); j++)
                exp_addr_q.push_back(base + 32'(4 * j));
        end
        for (int j = 0; j < int'(n); j++) begin
            logic [63:0] cat;
            cat = {rdm(base + 32'(4 * j + 4)), rdm(base + 32'(4 * j))};
            cat = cat >> (8 * sh);
            exp_data_q.push_back(cat[31:0]);
        end
    endtask

    task automatic wait_end(input string tag);
        for (int i = 0; i < 4000 && !dma_end; i++) @(negedge clk);
        chk(dma_end == 1'b1, {"R3 end flag ", tag}, {31'd0, dma_end}, 32'd1);
        chk(busy == 1'b0, {"R3 idle at end ", tag}, {31'd0, busy}, 32'd0);
        chk(exp_data_q.size() == 0, {"R4 all words delivered ", tag}, exp_data_q.size(), 0);
        chk(exp_addr_q.size() == 0, {"R2 all requests seen ", tag}, exp_addr_q.size(), 0);
    endtask

    initial begin
        for (int i = 0; i < 150000 && !finished; i++) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
        for (int i = 0; i < 512; i++) mem[i] = (i * 32'h9E3779B1) ^ 32'h13572468;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !dma_end, "R1 reset idle", {30'd0, busy, dma_end}, 32'd0);
        chk(!mem_req_valid && !fifo_valid, "R1 reset quiet", {30'd0, mem_req_valid, fifo_valid}, 32'd0);

        // Single descriptor, FIFO stalled at first, unaligned first-address write (R1, R9, R10)
        sink_mode = 2; lat = 1; ready_mode = 0;
        put_desc(32'h40, 32'h0, 32'h100, 32'd16, {16'd7, 14'd0, 2'b10}, 0);
        start_chain(32'h43, 32'h1);
        for (int i = 0; i < 200 && !fifo_valid; i++) @(negedge clk);
        chk(stat_desc_addr == 32'h40, "R9 descriptor address", stat_desc_addr, 32'h40);
        chk(stat_buf_addr == 32'h100, "R9 buffer address", stat_buf_addr, 32'h100);
        chk(stat_remain == 32'd16, "R9 remaining", stat_remain, 32'd16);
        chk(stat_desc_idx == 16'd7, "R3 index", {16'd0, stat_desc_idx}, 32'd7);
        begin
            logic [31:0] held;
            held = fifo_data;
            repeat (3) @(negedge clk);
            chk(fifo_valid && fifo_data == held, "R10 FIFO word held", fifo_data, held);
        end
        sink_mode = 0;
        wait_end("single");
        chk(stat_remain == 32'd0, "R9 remaining at end", stat_remain, 32'd0);
        chk(stat_buf_addr == 32'h110, "R9 buffer at end", stat_buf_addr, 32'h110);
        repeat (5) @(negedge clk);
        chk(dma_end == 1'b1, "R8 end flag held", {31'd0, dma_end}, 32'd1);
        wr_reg(1'b1, 32'h0);
        chk(dma_end == 1'b0, "R8 end flag cleared", {31'd0, dma_end}, 32'd0);

        // Three-link chain: empty middle segment, stray length bits, start write while busy
        lat = 3; ready_mode = 1; sink_mode = 1;
        put_desc(32'h00, 32'h20, 32'h140, 32'd8,  {16'd0, 14'd0, 2'b01}, 0);
        put_desc(32'h20, 32'h60, 32'h180, 32'd0,  {16'd1, 14'd0, 2'b01}, 0);
        put_desc(32'h60, 32'h0,  32'h1C0, 32'd15, {16'd2, 14'd0, 2'b10}, 0);
        start_chain(32'h00, 32'h1);
        wr_reg(1'b0, 32'h80);
        chk(busy == 1'b1, "R8 still busy before second start", {31'd0, busy}, 32'd1);
        wr_reg(1'b1, 32'h1);
        wait_end("chain R6");
        chk(stat_desc_addr == 32'h60, "R3 followed next pointer", stat_desc_addr, 32'h60);
        chk(stat_desc_idx == 16'd2, "R3 last index", {16'd0, stat_desc_idx}, 32'd2);
        repeat (10) @(negedge clk);
        chk(!busy, "R8 ignored start launched nothing", {31'd0, busy}, 32'd0);

        // Offset 1 chain (R5)
        lat = 2; ready_mode = 0; sink_mode = 0;
        put_desc(32'h80, 32'hA0, 32'h201, 32'd12, {16'd3, 14'd0, 2'b01}, 1);
        put_desc(32'hA0, 32'h0,  32'h241, 32'd4,  {16'd4, 14'd0, 2'b10}, 1);
        start_chain(32'h80, 32'h7);
        wait_end("offset1 R5");
        // Offset 3 (R5)
        put_desc(32'hC0, 32'h0, 32'h283, 32'd8, {16'd5, 14'd0, 2'b10}, 3);
        start_chain(32'hC0, 32'hF);
        wait_end("offset3 R5");
        // Offset bits without align enable (R5)
        put_desc(32'hC0, 32'h0, 32'h2C0, 32'd8, {16'd6, 14'd0, 2'b10}, 0);
        start_chain(32'hC0, 32'h9);
        wait_end("no align R5");
        // Empty last segment with offset (R6)
        put_desc(32'hC0, 32'h0, 32'h2C2, 32'd3, {16'd8, 14'd0, 2'b10}, 2);
        start_chain(32'hC0, 32'hB);
        wait_end("empty R6");

        // Abort during data with a slow read outstanding (R7)
        lat = 8; ready_mode = 0; sink_mode = 1;
        put_desc(32'hE0, 32'h0, 32'h300, 32'd64, {16'd9, 14'd0, 2'b10}, 0);
        start_chain(32'hE0, 32'h1);
        for (int i = 0; i < 2000 && exp_data_q.size() > 14; i++) @(negedge clk);
        for (int i = 0; i < 200 && !outstanding; i++) @(negedge clk);
        wr_reg(1'b1, 32'h0);
        exp_data_q.delete();
        exp_addr_q.delete();
        chk(!busy && !fifo_valid && !dma_end, "R7 abort to idle",
            {29'd0, busy, fifo_valid, dma_end}, 32'd0);
        repeat (3) @(negedge clk);
        chk(!fifo_valid && !busy, "R7 no words after abort", {30'd0, fifo_valid, busy}, 32'd0);
        put_desc(32'hF0, 32'h0, 32'h340, 32'd8, {16'd5, 14'd0, 2'b10}, 0);
        start_chain(32'hF0, 32'h1);
        wait_end("after abort R7");
        chk(stat_desc_idx == 16'd5, "R7 fresh chain index", {16'd0, stat_desc_idx}, 32'd5);

        repeat (20) @(negedge clk);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule